// File: doc/BRIEF.md
# Shared-Counter Ramp Converter Digital Back-End

This block is the digital half of a bank of single-slope ramp converters that sit in a multi-channel front-end. It contains one free-running 12-bit counter and one capture slice for each channel. The counter value goes out to the slices as a Gray-coded bus. Each slice freezes that bus value on the first rising edge of its own end-of-ramp comparator strobe. When several slices sample an asynchronous edge during a counter step, the Gray coding limits the error of any one of them to a single code.

Each stored code is decoded back to plain binary and is reported together with the gain-range bit that was applied to the channel when the code was frozen. An active-low start command begins a conversion. The counter then runs to full scale. Any channel that has not fired by then receives the full-scale value. A level-type done flag is raised, and the counter holds its value until the next start. The same counter suits a ramp time measurement. The analog ramp and the comparators lie outside the block.

Top module: `wadc_backend`

## Requirements
- R1: After reset, `done` is 0 and every channel's result code and gain bit are 0.
- R2: A clock edge that samples `start_conv_n` low clears the counter and `done`. If a start arrives while a conversion is running, the count restarts from that edge.
- R3: Let E0 be the start edge. If a strobe is driven high d cycles after E0 (first sampled at edge E0+d+1), the channel reports the binary value d+2. This value accounts for two synchroniser flops and one edge-detect flop.
- R4: Only the first rising strobe edge in a conversion is stored. A later fall and rise of the strobe in the same conversion, or after `done`, leaves the code and the gain unchanged.
- R5: A strobe that is already high when the conversion starts does not count as an edge. That channel reports overflow.
- R6: A channel with no stored edge by full scale reports 4095.
- R7: The gain bit reported for a channel is the value of `gain_hi` at the edge where that channel's result is stored. Changes to `gain_hi` after that edge do not affect it.
- R8: `done` goes to 1 exactly 4096 edges after E0, while it reads 0 after edge E0+4095. It then stays 1, and results stay fixed, until the next start.
- R9: Codes on the internal counter bus change by exactly one bit per count step, so every reported value decodes to the exact count.
- R10: Channels are independent of one another. Each result depends only on that channel's own strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_conv_n | input | 1 | Active-low start-of-conversion command, sampled on clk |
| ramp_end | input | N_CH | Per-channel end-of-ramp comparator strobes (asynchronous) |
| gain_hi | input | N_CH | Per-channel gain-range bit (1 = high gain) |
| result_code | output | N_CH*CNT_W | Binary results, channel c in bits [c*CNT_W +: CNT_W] |
| result_gain | output | N_CH | Gain bit stored with each result |
| done | output | 1 | Conversion complete, held until the next start |

## Verification
A counter or Gray bus that skips or repeats a step shows up as a channel result that differs from d+2. A faulty decode shows up the same way. Because the strobe delays in one conversion span dozens of distinct counts, the error appears at the ports in the same conversion. A capture flag that is lost or set early shows up in two ways: a repeated strobe overwrites a value, or a held-high strobe yields a real code instead of 4095. Both are visible once done rises, 4096 cycles after the start. An end-of-count off by one moves the done edge by one cycle, and the bench samples that edge exactly.

// File: rtl/wadc_pkg.sv
package wadc_pkg;

  // Binary to Gray: each bit XORed with its upper neighbour.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray to binary: XOR of all right shifts of the code.
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] acc;
    acc = g;
    for (int i = 1; i < 32; i++) begin
      acc = acc ^ (g >> i);
    end
    return acc;
  endfunction

endpackage

// File: rtl/wadc_timebase.sv
module wadc_timebase #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] gray_bus,
  output logic             running,
  output logic             fin,
  output logic             done
);
  import wadc_pkg::*;

  localparam logic [CNT_W-1:0] FULL      = '1;
  localparam logic [CNT_W-1:0] FULL_GRAY = FULL ^ (FULL >> 1);

  logic [CNT_W-1:0] cnt_q;

  // Full-scale event: the edge at which the conversion ends.
  assign fin = running && (cnt_q == FULL) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      gray_bus <= '0;
      running  <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      cnt_q    <= '0;
      gray_bus <= '0;
      running  <= 1'b1;
      done     <= 1'b0;
    end else if (fin) begin
      running  <= 1'b0;
      done     <= 1'b1;
    end else if (running) begin
      cnt_q    <= cnt_q + 1'b1;
      gray_bus <= CNT_W'(bin2gray(32'(cnt_q) + 32'd1));
    end
  end

  // R9: one bit flips per count step
  p_gray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fin && !start) |=> $countones(gray_bus ^ $past(gray_bus)) == 1);

  // R8: done only rises from full scale
  p_done_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(gray_bus) == FULL_GRAY);

  // R8: counter and done hold until next start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(gray_bus));

  // R2: start clears count and done
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && running && gray_bus == '0);

endmodule

// File: rtl/wadc_chan_latch.sv
module wadc_chan_latch #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             running,
  input  logic             fin,
  input  logic [CNT_W-1:0] gray_bus,
  input  logic             ramp_end,
  input  logic             gain_in,
  output logic [CNT_W-1:0] code,
  output logic             gain,
  output logic             captured
);
  import wadc_pkg::*;

  localparam logic [CNT_W-1:0] FULL      = '1;
  localparam logic [CNT_W-1:0] FULL_GRAY = FULL ^ (FULL >> 1);

  logic [SYNC_STAGES:0] chain_q;
  logic [CNT_W-1:0]     code_g;
  logic                 rise;

  // Synchroniser stages followed by one edge-detect flop.
  assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q  <= '0;
      code_g   <= '0;
      gain     <= 1'b0;
      captured <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-1:0], ramp_end};
      if (start) begin
        captured <= 1'b0;
      end else if (rise && running && !captured) begin
        code_g   <= gray_bus;
        gain     <= gain_in;
        captured <= 1'b1;
      end else if (fin && !captured) begin
        code_g   <= FULL_GRAY;
        gain     <= gain_in;
        captured <= 1'b1;
      end
    end
  end

  assign code = CNT_W'(gray2bin(32'(code_g)));

  // R4: a stored result is frozen until the next start
  p_single_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && !start) |=> $stable(code_g) && $stable(gain));

endmodule

// File: rtl/wadc_backend.sv
module wadc_backend #(
  parameter int N_CH        = 36,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_conv_n,
  input  logic [N_CH-1:0]       ramp_end,
  input  logic [N_CH-1:0]       gain_hi,
  output logic [N_CH*CNT_W-1:0] result_code,
  output logic [N_CH-1:0]       result_gain,
  output logic                  done
);

  logic             start;
  logic [CNT_W-1:0] gray_bus;
  logic             running;
  logic             fin;
  logic [N_CH-1:0]  captured_vec;

  assign start = !start_conv_n;

  wadc_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .gray_bus (gray_bus),
    .running  (running),
    .fin      (fin),
    .done     (done)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    wadc_chan_latch #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .running  (running),
      .fin      (fin),
      .gray_bus (gray_bus),
      .ramp_end (ramp_end[c]),
      .gain_in  (gain_hi[c]),
      .code     (result_code[c*CNT_W +: CNT_W]),
      .gain     (result_gain[c]),
      .captured (captured_vec[c])
    );
  end

  // R6: when done is up, every channel holds a result
  p_all_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> &captured_vec);

  // R5/R10: no channel can hold a result right after a start
  p_start_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> captured_vec == '0);

endmodule

// File: tb/wadc_backend_tb.sv
`timescale 1ns/1ps
module wadc_backend_tb;
  localparam int N_CH  = 36;
  localparam int CNT_W = 12;
  localparam int FULL  = 4095;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start_conv_n = 1'b1;
  logic [N_CH-1:0]       ramp_end = '0;
  logic [N_CH-1:0]       gain_hi = '0;
  logic [N_CH*CNT_W-1:0] result_code;
  logic [N_CH-1:0]       result_gain;
  logic                  done;

  int checks = 0;
  int errors = 0;
  int dly [N_CH];

  // base, step, modulus, gain-flip cycle (-1 = none)
  localparam int VEC [5][4] = '{
    '{0,    1,   36,   -1},
    '{10,   117, 4090, -1},
    '{5,    97,  3000, 1500},
    '{4080, 1,   4100, -1},
    '{4000, 503, 5000, 4095}
  };

  always #2.5 clk = ~clk;

  wadc_backend u_dut (
    .clk(clk), .rst_n(rst_n), .start_conv_n(start_conv_n),
    .ramp_end(ramp_end), .gain_hi(gain_hi),
    .result_code(result_code), .result_gain(result_gain), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one conversion; pre_high strobes are raised well before start.
  task automatic run_conv(input int gflip, input bit repulse, input logic [N_CH-1:0] pre_high);
    logic [N_CH-1:0] g0;
    int capk;
    int exp_code;
    @(negedge clk);
    ramp_end = pre_high;
    repeat (4) @(negedge clk);
    g0 = gain_hi;
    start_conv_n = 1'b0;
    @(negedge clk);
    start_conv_n = 1'b1;
    for (int k = 0; k < 4100; k++) begin
      if (k == 4095) check(done == 1'b0, "R8 done early", int'(done), 0);
      if (k == 4096) check(done == 1'b1, "R8 done edge", int'(done), 1);
      for (int c = 0; c < N_CH; c++) begin
        if (!pre_high[c]) begin
          if (dly[c] == k) ramp_end[c] = 1'b1;
          if (repulse && dly[c] + 4 == k) ramp_end[c] = 1'b0;
          if (repulse && dly[c] + 8 == k) ramp_end[c] = 1'b1;
        end
      end
      if (gflip == k) gain_hi = ~gain_hi;
      @(negedge clk);
    end
    for (int c = 0; c < N_CH; c++) begin
      if (pre_high[c]) begin
        exp_code = FULL;
        capk = 4096;
      end else begin
        exp_code = (dly[c] + 2 > FULL) ? FULL : dly[c] + 2;
        capk = (dly[c] + 3 > 4096) ? 4096 : dly[c] + 3;
      end
      // R3 R6 R9 R10 value; R4 with repulse; R5 with pre_high
      check(int'(result_code[c*CNT_W +: CNT_W]) == exp_code,
            pre_high[c] ? "R5 held-high strobe" : (repulse ? "R4/R3 code" : "R3/R6/R10 code"),
            int'(result_code[c*CNT_W +: CNT_W]), exp_code);
      check(result_gain[c] == (g0[c] ^ (gflip >= 0 && gflip < capk)), "R7 gain",
            int'(result_gain[c]), int'(g0[c] ^ (gflip >= 0 && gflip < capk)));
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N_CH*CNT_W-1:0] snap;
    logic [N_CH-1:0]       gsnap;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(result_code == '0, "R1 codes", int'(result_code[CNT_W-1:0]), 0);
    check(result_gain == '0, "R1 gains", int'(result_gain[0]), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      for (int c = 0; c < N_CH; c++) begin
        dly[c] = (VEC[v][0] + c * VEC[v][1]) % VEC[v][2];
        gain_hi[c] = ((c + v) % 3 == 0);
      end
      run_conv(VEC[v][3], v == 2, (v == 3) ? 36'hF : '0);
    end

    // R2: start during a running conversion restarts the count
    @(negedge clk);
    start_conv_n = 1'b0;
    @(negedge clk);
    start_conv_n = 1'b1;
    repeat (50) @(negedge clk);
    ramp_end = '1;
    repeat (50) @(negedge clk);
    check(done == 1'b0, "R2 running before restart", int'(done), 0);
    for (int c = 0; c < N_CH; c++) dly[c] = 3 * c + 1;
    run_conv(-1, 1'b0, '0);

    // R8/R4: after done, new strobe edges and waiting change nothing
    snap  = result_code;
    gsnap = result_gain;
    ramp_end = '0;
    gain_hi = ~gain_hi;
    repeat (5) @(negedge clk);
    ramp_end = '1;
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R8 done held", int'(done), 1);
    check(result_code == snap, "R8/R4 codes held", int'(result_code[CNT_W-1:0]), int'(snap[CNT_W-1:0]));
    check(result_gain == gsnap, "R7/R8 gains held", int'(result_gain[0]), int'(gsnap[0]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule